// File: doc/BRIEF.md
# I2C Message List Transfer Sequencer

This block carries out an ordered list of I2C messages without processor help for each byte. Each message is described by a 7-bit target address, a read flag and a byte count, all fetched through a descriptor port indexed by message number. The sequencer drives a separate byte-level bus engine through a command interface with four operations: START plus address byte, WRITE one byte, READ one byte, and STOP. It waits for that engine's per-byte completion pulse before deciding the next step. Write bytes come from an external buffer port and read bytes go back to it. The buffer is addressed by the message number concatenated with the byte position inside that message.

A list is launched with a single-cycle `go_i` pulse while the block is idle. Consecutive messages are joined with repeated STARTs, and one STOP closes the list. A zero-length final message probes for a device: it sends the address alone and then stops. The outcome is reported with a done pulse and a two-bit status: success, no device (any missing acknowledge), or timeout. A cycle counter bounds the whole transfer. An arbitration-lost indication from the engine is kept as a sticky flag for the list in which it occurred.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset the block is idle (`busy_o`=0), `done_o`=0, `cmd_valid_o`=0, `arb_lost_o`=0 and `status_o` is 2'b01 (no device).
- R2: Each message begins with one command of opcode 0 (START). Its `cmd_data_o` is the address in bits 7:1 and the read flag in bit 0, where 1 means read and 0 means write. `cmd_rd_o` equals that flag. The first such command follows `go_i`.
- R3: If the engine reports NACK (`eng_nack_i`=1 with `eng_done_i`) for an address, the next command is STOP (opcode 3), no further message is attempted and the final status is 2'b01.
- R4: If the last message has length 0 and its address is acknowledged, the sequencer issues STOP at once and the final status is 2'b00.
- R5: A write message issues one WRITE (opcode 1) per byte, taking bytes from buffer address {message index, byte position} in rising order. A NACK on any written byte ends the list with STOP and status 2'b01.
- R6: A read message issues one READ (opcode 2) per byte and stores each completed byte `eng_rdata_i` at buffer address {message index, byte position}. `cmd_ack_o` is 1 on every READ except the one for the message's last byte, where it is 0.
- R7: When a message finishes and more remain, the next message starts with a repeated START and no STOP. A zero-length message that is not the last sends only its address.
- R8: After the last byte of the last message exactly one STOP is issued. Its `cmd_rd_o` is the read flag of the message in progress. Once the engine reports not busy, `done_o` pulses for one cycle, `busy_o` falls and the status is 2'b00.
- R9: From the cycle after an accepted `go_i` until completion, `status_o` reads 2'b01.
- R10: If a list has not completed TIMEOUT_CYC cycles after it was accepted, the block returns to idle with a done pulse and status 2'b10.
- R11: `eng_arb_lost_i` seen during a transfer sets `arb_lost_o`, which stays set until the next accepted `go_i` clears it.
- R12: `go_i` and `num_msgs_i` are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Launch the list (accepted only when idle) |
| num_msgs_i | input | NUM_W | Number of messages in the list, 1..MAX_MSGS |
| desc_idx_o | output | IDX_W | Index of the descriptor being read |
| desc_addr_i | input | 7 | Target address of the indexed message |
| desc_rd_i | input | 1 | Read flag of the indexed message |
| desc_len_i | input | LEN_W | Byte count of the indexed message |
| buf_addr_o | output | IDX_W+LEN_W | Buffer address {message index, byte position} |
| buf_rdata_i | input | 8 | Buffer read data (combinational) |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| cmd_valid_o | output | 1 | One-cycle command strobe to the byte engine |
| cmd_op_o | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data_o | output | 8 | Address byte or write byte |
| cmd_ack_o | output | 1 | Acknowledge the byte being read |
| cmd_rd_o | output | 1 | Direction of the current message |
| eng_done_i | input | 1 | Byte phase finished |
| eng_nack_i | input | 1 | Acknowledge bit sampled high |
| eng_rdata_i | input | 8 | Received byte |
| eng_busy_i | input | 1 | Bus held by the engine |
| eng_arb_lost_i | input | 1 | Arbitration lost pulse |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 success, 01 no device, 10 timeout |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |

## Verification
The bench targets several boundary cases. A zero-length last message must produce address then STOP; a design that treats it like a write would hang or emit a WRITE. A zero-length middle message must fall through to a repeated START; a wrong design would either stop early or insert a STOP between messages. Single-byte reads must carry NACK on their only byte, and a design that checks "last byte" one position late would acknowledge it. A NACK on a middle write byte must stop the list immediately, where a faulty design would keep streaming. The bench also hangs the engine to force the timeout, raises arbitration loss to see the sticky flag set and then cleared by the next list, and pulses `go_i` with a different message count mid-transfer, which a design that re-latches it would obey.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_START, S_WRITE, S_READ, S_STOP} seq_state_e;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} byte_op_e;
  typedef enum logic [1:0] {XS_OK = 2'd0, XS_NODEV = 2'd1, XS_TIMEOUT = 2'd2} xfer_status_e;
  typedef enum logic [2:0] {
    ACT_NONE, ACT_WRITE, ACT_READ, ACT_NEXT, ACT_STOP_OK, ACT_STOP_ND
  } seq_act_e;
endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int unsigned LIMIT = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int MAX_MSGS = 4,
  parameter int LEN_W    = 4,
  localparam int IDX_W   = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
  localparam int NUM_W   = $clog2(MAX_MSGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [NUM_W-1:0]       num_msgs_i,
  input  logic                   expired_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LEN_W-1:0]       ptr_o,
  input  logic [6:0]             desc_addr_i,
  input  logic                   desc_rd_i,
  input  logic [LEN_W-1:0]       desc_len_i,
  input  logic [7:0]             buf_rdata_i,
  output logic                   buf_we_o,
  output logic                   cmd_valid_o,
  output logic [1:0]             cmd_op_o,
  output logic [7:0]             cmd_data_o,
  output logic                   cmd_ack_o,
  output logic                   cmd_rd_o,
  input  logic                   eng_done_i,
  input  logic                   eng_nack_i,
  input  logic                   eng_busy_i,
  input  logic                   eng_arb_lost_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             status_o,
  output logic                   arb_lost_o
);
  seq_state_e       state_q;
  seq_act_e         act;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [LEN_W-1:0] ptr_q;
  logic             pend_q;
  logic             cmd_valid_q, cmd_ack_q, cmd_rd_q;
  byte_op_e         cmd_op_q;
  logic [7:0]       cmd_data_q;
  xfer_status_e     status_q;
  logic             arb_q, done_q;

  logic             is_last, more_bytes, read_ack;
  logic [LEN_W:0]   ptr_nx;
  logic [LEN_W+1:0] rd_base;

  assign is_last    = (idx_q == last_q);
  assign more_bytes = (ptr_q < desc_len_i);
  assign ptr_nx     = {1'b0, ptr_q} + 1'b1;
  assign rd_base    = (state_q == S_READ) ? {1'b0, ptr_nx} : '0;
  assign read_ack   = (rd_base + 1'b1) < {2'b00, desc_len_i};
  assign buf_we_o   = (state_q == S_READ) && eng_done_i;

  always_comb begin
    act = ACT_NONE;
    if (eng_done_i && !pend_q) begin
      unique case (state_q)
        S_START:
          if (eng_nack_i)               act = ACT_STOP_ND;
          else if (desc_len_i == '0)    act = is_last ? ACT_STOP_OK : ACT_NEXT;
          else if (desc_rd_i)           act = ACT_READ;
          else                          act = ACT_WRITE;
        S_WRITE:
          if (eng_nack_i)               act = ACT_STOP_ND;
          else if (more_bytes)          act = ACT_WRITE;
          else if (!is_last)            act = ACT_NEXT;
          else                          act = ACT_STOP_OK;
        S_READ:
          if (ptr_nx < {1'b0, desc_len_i}) act = ACT_READ;
          else if (!is_last)            act = ACT_NEXT;
          else                          act = ACT_STOP_OK;
        default:                        act = ACT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      ptr_q       <= '0;
      pend_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_START;
      cmd_data_q  <= '0;
      cmd_ack_q   <= 1'b0;
      cmd_rd_q    <= 1'b0;
      status_q    <= XS_NODEV;
      arb_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      done_q      <= 1'b0;
      if (state_q != S_IDLE && eng_arb_lost_i) arb_q <= 1'b1;
      if (state_q != S_IDLE && expired_i) begin
        state_q  <= S_IDLE;
        status_q <= XS_TIMEOUT;
        done_q   <= 1'b1;
        idx_q    <= '0;
        ptr_q    <= '0;
        pend_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE:
            if (go_i) begin
              last_q   <= IDX_W'(num_msgs_i - 1'b1);
              idx_q    <= '0;
              ptr_q    <= '0;
              status_q <= XS_NODEV;
              arb_q    <= 1'b0;
              pend_q   <= 1'b1;
              state_q  <= S_START;
            end
          S_STOP:
            if (!cmd_valid_q && !eng_busy_i) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              idx_q   <= '0;
              ptr_q   <= '0;
            end
          default: begin
            if (state_q == S_START && pend_q) begin
              cmd_valid_q <= 1'b1;
              cmd_op_q    <= OP_START;
              cmd_data_q  <= {desc_addr_i, desc_rd_i};
              cmd_rd_q    <= desc_rd_i;
              pend_q      <= 1'b0;
            end
            unique case (act)
              ACT_WRITE: begin
                cmd_valid_q <= 1'b1;
                cmd_op_q    <= OP_WRITE;
                cmd_data_q  <= buf_rdata_i;
                ptr_q       <= ptr_q + 1'b1;
                state_q     <= S_WRITE;
              end
              ACT_READ: begin
                cmd_valid_q <= 1'b1;
                cmd_op_q    <= OP_READ;
                cmd_ack_q   <= read_ack;
                if (state_q == S_READ) ptr_q <= ptr_nx[LEN_W-1:0];
                state_q     <= S_READ;
              end
              ACT_NEXT: begin
                idx_q   <= idx_q + 1'b1;
                ptr_q   <= '0;
                pend_q  <= 1'b1;
                state_q <= S_START;
              end
              ACT_STOP_OK, ACT_STOP_ND: begin
                cmd_valid_q <= 1'b1;
                cmd_op_q    <= OP_STOP;
                cmd_rd_q    <= desc_rd_i;
                if (act == ACT_STOP_OK) status_q <= XS_OK;
                state_q     <= S_STOP;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  assign idx_o       = idx_q;
  assign ptr_o       = ptr_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign cmd_data_o  = cmd_data_q;
  assign cmd_ack_o   = cmd_ack_q;
  assign cmd_rd_o    = cmd_rd_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign status_o    = status_q;
  assign arb_lost_o  = arb_q;
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
  parameter int          MAX_MSGS    = 4,
  parameter int          LEN_W       = 4,
  parameter int unsigned TIMEOUT_CYC = 1000000,
  localparam int         IDX_W       = (MAX_MSGS > 1) ? $clog2(MAX_MSGS) : 1,
  localparam int         NUM_W       = $clog2(MAX_MSGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [NUM_W-1:0]       num_msgs_i,
  output logic [IDX_W-1:0]       desc_idx_o,
  input  logic [6:0]             desc_addr_i,
  input  logic                   desc_rd_i,
  input  logic [LEN_W-1:0]       desc_len_i,
  output logic [IDX_W+LEN_W-1:0] buf_addr_o,
  input  logic [7:0]             buf_rdata_i,
  output logic                   buf_we_o,
  output logic [7:0]             buf_wdata_o,
  output logic                   cmd_valid_o,
  output logic [1:0]             cmd_op_o,
  output logic [7:0]             cmd_data_o,
  output logic                   cmd_ack_o,
  output logic                   cmd_rd_o,
  input  logic                   eng_done_i,
  input  logic                   eng_nack_i,
  input  logic [7:0]             eng_rdata_i,
  input  logic                   eng_busy_i,
  input  logic                   eng_arb_lost_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             status_o,
  output logic                   arb_lost_o
);
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] ptr;
  logic             expired;

  i2c_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(busy_o), .expired_o(expired)
  );

  i2c_seq_ctrl #(.MAX_MSGS(MAX_MSGS), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .go_i, .num_msgs_i, .expired_i(expired),
    .idx_o(idx), .ptr_o(ptr),
    .desc_addr_i, .desc_rd_i, .desc_len_i, .buf_rdata_i, .buf_we_o,
    .cmd_valid_o, .cmd_op_o, .cmd_data_o, .cmd_ack_o, .cmd_rd_o,
    .eng_done_i, .eng_nack_i, .eng_busy_i, .eng_arb_lost_i,
    .busy_o, .done_o, .status_o, .arb_lost_o
  );

  assign desc_idx_o  = idx;
  assign buf_addr_o  = {idx, ptr};
  assign buf_wdata_o = eng_rdata_i;
endmodule

// File: rtl/i2c_msg_seq_checker.sv
module i2c_msg_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o,
  input logic       cmd_valid_o,
  input logic [1:0] cmd_op_o,
  input logic [7:0] cmd_data_o,
  input logic       cmd_rd_o,
  input logic       arb_lost_o
);
  assert_start_dir_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd0) |-> (cmd_data_o[0] == cmd_rd_o));

  assert_read_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd2) |-> cmd_rd_o);

  assert_cmd_in_xfer_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_status_nodev_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (status_o == 2'b01));

  assert_arb_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && busy_o) |=> arb_lost_o);
endmodule

bind i2c_msg_seq i2c_msg_seq_checker u_chk (.*);

// File: tb/i2c_msg_seq_test.sv
module i2c_msg_seq_test;
  localparam int MM = 4, LW = 4, TO = 1500, AW = 6;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic go = 0;
  logic [2:0] num = 3'd1;
  logic [1:0] desc_idx;
  logic [6:0] d_addr [MM];
  logic       d_rd   [MM];
  logic [3:0] d_len  [MM];
  logic [7:0] mem [64];
  logic [AW-1:0] buf_addr;
  logic buf_we; logic [7:0] buf_wdata;
  logic cmd_valid, cmd_ack, cmd_rd; logic [1:0] cmd_op; logic [7:0] cmd_data;
  logic eng_done = 0, eng_nack = 0, eng_busy = 0, eng_arb = 0;
  logic [7:0] eng_rdata = 0;
  logic busy, done; logic [1:0] status; logic arb_lost;

  i2c_msg_seq #(.MAX_MSGS(MM), .LEN_W(LW), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .num_msgs_i(num),
    .desc_idx_o(desc_idx), .desc_addr_i(d_addr[desc_idx]), .desc_rd_i(d_rd[desc_idx]),
    .desc_len_i(d_len[desc_idx]), .buf_addr_o(buf_addr), .buf_rdata_i(mem[buf_addr]),
    .buf_we_o(buf_we), .buf_wdata_o(buf_wdata), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_data_o(cmd_data), .cmd_ack_o(cmd_ack), .cmd_rd_o(cmd_rd),
    .eng_done_i(eng_done), .eng_nack_i(eng_nack), .eng_rdata_i(eng_rdata),
    .eng_busy_i(eng_busy), .eng_arb_lost_i(eng_arb),
    .busy_o(busy), .done_o(done), .status_o(status), .arb_lost_o(arb_lost));

  // engine model config and log
  bit hang = 0, arb_on = 0;
  int wr_nack_at = -1;
  logic [7:0] rd_seed = 8'h3c;
  int n_log = 0, wr_idx = 0, rd_cnt = 0, cnt = 0, stop_cnt = 0;
  logic pend_nack = 0; logic [7:0] pend_rd = 0;
  int lg_op [64]; int lg_val [64];

  function automatic bit present(input logic [6:0] a);
    return a[6:4] == 3'b101;
  endfunction

  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  always @(posedge clk) begin
    eng_done <= 0; eng_arb <= 0;
    if (go && !busy) begin n_log = 0; wr_idx = 0; rd_cnt = 0; end
    if (cmd_valid && !hang) begin
      if (n_log < 64) begin
        lg_op[n_log] = int'(cmd_op);
        lg_val[n_log] = (cmd_op == 2'd2) ? int'(cmd_ack) : (cmd_op == 2'd3) ? int'(cmd_rd) : int'(cmd_data);
        n_log++;
      end
      case (cmd_op)
        2'd0: begin eng_busy <= 1; pend_nack = !present(cmd_data[7:1]); cnt = 2 + int'($urandom_range(3)); if (arb_on) eng_arb <= 1; end
        2'd1: begin pend_nack = (wr_idx == wr_nack_at); wr_idx++; cnt = 2 + int'($urandom_range(3)); end
        2'd2: begin pend_rd = rd_seed + 8'(rd_cnt * 29); rd_cnt++; pend_nack = !cmd_ack; cnt = 2 + int'($urandom_range(3)); end
        default: stop_cnt = 3;
      endcase
    end else begin
      if (cnt != 0) begin
        cnt--;
        if (cnt == 0) begin eng_done <= 1; eng_nack <= pend_nack; eng_rdata <= pend_rd; end
      end
      if (stop_cnt != 0) begin stop_cnt--; if (stop_cnt == 0) eng_busy <= 0; end
    end
  end

  int n_chk = 0, n_err = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s actual %0h expected %0h", req, act, exp); end
  endtask

  // expected model
  int eo [64]; int ev [64]; int n_exp; int exp_st;
  logic [7:0] em [64];
  task automatic build_exp();
    int wi = 0, ri = 0;
    n_exp = 0;
    for (int i = 0; i < 64; i++) em[i] = mem[i];
    for (int m = 0; m < int'(num); m++) begin
      eo[n_exp] = 0; ev[n_exp] = int'({d_addr[m], d_rd[m]}); n_exp++;
      if (!present(d_addr[m])) begin eo[n_exp] = 3; ev[n_exp] = int'(d_rd[m]); n_exp++; exp_st = 1; return; end
      for (int b = 0; b < int'(d_len[m]); b++) begin
        if (d_rd[m]) begin
          eo[n_exp] = 2; ev[n_exp] = (b < int'(d_len[m]) - 1) ? 1 : 0; n_exp++;
          em[m*16 + b] = rd_seed + 8'(ri * 29); ri++;
        end else begin
          eo[n_exp] = 1; ev[n_exp] = int'(mem[m*16 + b]); n_exp++;
          if (wi == wr_nack_at) begin eo[n_exp] = 3; ev[n_exp] = 0; n_exp++; exp_st = 1; return; end
          wi++;
        end
      end
    end
    eo[n_exp] = 3; ev[n_exp] = int'(d_rd[int'(num) - 1]); n_exp++; exp_st = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) check(0, "watchdog", 0, 1);
  endtask

  task automatic pulse_go();
    @(negedge clk); go = 1; @(negedge clk); go = 0;
  endtask

  task automatic run(input string req, input bit stray);
    int cyc, first_bad;
    logic [2:0] keep;
    build_exp();
    pulse_go();
    check(busy && status == 2'b01, "R9", int'(status), 1);
    if (stray) begin
      keep = num;
      repeat (6) @(negedge clk);
      num = 3'd1; go = 1; @(negedge clk); go = 0;
      repeat (3) @(negedge clk);
      num = keep;
    end
    wait_done(cyc);
    check(int'(status) == exp_st, req, int'(status), exp_st);
    check(!eng_busy && !busy, "R8", int'(eng_busy), 0);
    first_bad = (n_log != n_exp) ? 100 : -1;
    for (int i = 0; i < n_exp && first_bad < 0; i++)
      if (lg_op[i] != eo[i] || lg_val[i] != ev[i]) first_bad = i;
    check(first_bad < 0, req, n_log, n_exp);
    first_bad = -1;
    for (int i = 0; i < 64; i++) if (mem[i] !== em[i] && first_bad < 0) first_bad = i;
    check(first_bad < 0, "R6", first_bad, -1);
    @(negedge clk);
    check(!done, "R8", int'(done), 0);
  endtask

  task automatic set_msg(input int m, input logic [6:0] a, input logic r, input int l);
    d_addr[m] = a; d_rd[m] = r; d_len[m] = 4'(l);
  endtask

  initial begin
    int cyc;
    void'($urandom(32'd11));
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    for (int m = 0; m < MM; m++) set_msg(m, 7'h50, 0, 0);
    repeat (3) @(negedge clk);
    check(!busy && !done && !cmd_valid && !arb_lost && status == 2'b01, "R1", int'(status), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    num = 1; set_msg(0, 7'h50, 0, 2); run("R5", 0);
    num = 2; set_msg(0, 7'h51, 0, 1); set_msg(1, 7'h51, 1, 3); run("R7", 0);
    num = 1; set_msg(0, 7'h52, 0, 0); run("R4", 0);
    num = 2; set_msg(0, 7'h20, 0, 2); set_msg(1, 7'h50, 1, 2); run("R3", 0);
    wr_nack_at = 1; num = 1; set_msg(0, 7'h53, 0, 4); run("R5", 0); wr_nack_at = -1;
    num = 1; set_msg(0, 7'h54, 1, 1); run("R6", 0);
    num = 3; set_msg(0, 7'h55, 0, 2); set_msg(1, 7'h56, 0, 0); set_msg(2, 7'h57, 1, 2); run("R7", 0);
    num = 3; set_msg(0, 7'h50, 1, 3); set_msg(1, 7'h51, 0, 3); set_msg(2, 7'h52, 1, 2); run("R12", 1);

    arb_on = 1; num = 1; set_msg(0, 7'h50, 0, 1); run("R8", 0); arb_on = 0;
    check(arb_lost == 1'b1, "R11", int'(arb_lost), 1);
    num = 1; set_msg(0, 7'h50, 0, 1); run("R8", 0);
    check(arb_lost == 1'b0, "R11", int'(arb_lost), 0);

    hang = 1; num = 1; set_msg(0, 7'h50, 0, 1);
    pulse_go();
    wait_done(cyc);
    check(status == 2'b10, "R10", int'(status), 2);
    check(cyc >= TO - 3 && cyc <= TO + 3, "R10", cyc, TO);
    hang = 0;
    repeat (3) @(negedge clk);

    for (int it = 0; it < 30; it++) begin
      num = 3'(1 + $urandom_range(3));
      for (int m = 0; m < MM; m++)
        set_msg(m, ($urandom_range(9) == 0) ? 7'h21 : 7'(7'h50 + $urandom_range(15)),
                1'($urandom_range(1)), int'($urandom_range(5)));
      for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
      wr_nack_at = ($urandom_range(4) == 0) ? int'($urandom_range(3)) : -1;
      rd_seed = 8'($urandom);
      run("R2", 0);
    end
    wr_nack_at = -1;

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule